// File: doc/BRIEF.md
# Dual-Bank Fast/Normal Interrupt Controller

The controller gathers level-sensitive interrupt sources and presents them to one core as two request lines, a fast-interrupt line and a normal-interrupt line. The sources are split across two banks. The low bank always holds 32 sources. The high bank holds the rest, `NUM_SRC - 32` sources, which is 8 by default. Each source has three stored bits: an enable bit, a routing bit that sends it to the fast line when set or the normal line when clear, and a pending bit. The pending bit copies the source input on every clock edge. It is never latched and cannot be cleared by a write.

Software reaches the controller over a 32-bit bus. The bus has a byte offset, a write strobe, and a read path that is combinational on the offset. Software can read the raw pending bits, the pending bits filtered per line, and the enable and routing registers. A one-bit wake-policy register controls which pending sources raise a wake request while the core reports that it is halted. The highest-priority lookup is a separate block. Its result enters on `hp_data_i` and is returned at its own offset.

Top module: `dbic_top`

## Requirements
- R1: Each pending bit equals the level of its source input sampled at the previous rising clock edge. When an input falls, its pending bit clears at the next edge.
- R2: Offset 0x10 returns the raw pending bits of the low bank. Offset 0xAC returns those of the high bank. Bits above the high-bank width read 0.
- R3: Offsets 0x00 (low bank) and 0x9C (high bank) return pending AND enable AND NOT routing.
- R4: Offsets 0x0C (low bank) and 0xA8 (high bank) return pending AND enable AND routing.
- R5: The enable registers are at 0x04 and 0xA0. The routing registers are at 0x08 and 0xA4. Each is written on the clock edge of a write and reads back the written value. High-bank bits above the bank width are not stored and read 0.
- R6: `fiq_o` is high exactly when some source in either bank is pending, enabled and has its routing bit set.
- R7: `irq_o` is high exactly when some source in either bank is pending, enabled and has its routing bit clear.
- R8: Bit 0 of offset 0x14 is the wake policy. 1 means only enabled sources wake the core. 0 means any pending source does. A read of 0x14 returns the policy in bit 0 and 0 in all other bits.
- R9: `wake_o` is high exactly when `core_halted_i` is high and, in either bank, some pending bit is set whose enable bit is set or whose policy allows wake-all (policy 0).
- R10: After reset, the enable, routing, pending and policy state is all zero.
- R11: Writes to 0x00, 0x0C, 0x10, 0x18, 0x9C, 0xA8, 0xAC and to any unmapped offset change no state. Reads of unmapped offsets return 0.
- R12: Offset 0x18 returns `hp_data_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Source levels. Bits 31:0 go to the low bank, the rest to the high bank |
| addr_i | input | 8 | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe. The write takes effect at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on `addr_i` |
| hp_data_i | input | 32 | Result from the external highest-priority lookup |
| core_halted_i | input | 1 | The core reports that it is halted |
| fiq_o | output | 1 | Fast-interrupt request |
| irq_o | output | 1 | Normal-interrupt request |
| wake_o | output | 1 | Wake request to the halted core |

## Verification
The bench builds the controller with `NUM_SRC = 36`, so the high bank is 4 sources wide. This makes the high bank small enough to sweep every combination of pending, enable and routing bits (4096 cases), checking both filtered views and both request lines in each case. The wake output is swept over every pending and enable pattern of the high bank under both policies, with the core halted and with it running. The 32-source low bank is covered by a walking single source with alternating routing and by a set of mixed patterns. A width of 4 also puts the unstored upper bits of the high-bank registers well inside the 32-bit read word, where they must read as zero.

// File: rtl/dbic_pkg.sv
package dbic_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  localparam int LO_W   = 32;

  localparam logic [ADDR_W-1:0] OFS_IRQ0  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_EN0   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_RT0   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_FIQ0  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PND0  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_HP    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IRQ1  = 8'h9C;
  localparam logic [ADDR_W-1:0] OFS_EN1   = 8'hA0;
  localparam logic [ADDR_W-1:0] OFS_RT1   = 8'hA4;
  localparam logic [ADDR_W-1:0] OFS_FIQ1  = 8'hA8;
  localparam logic [ADDR_W-1:0] OFS_PND1  = 8'hAC;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_IRQ0, SEL_EN0, SEL_RT0, SEL_FIQ0, SEL_PND0, SEL_CTRL, SEL_HP,
    SEL_IRQ1, SEL_EN1, SEL_RT1, SEL_FIQ1, SEL_PND1
  } rd_sel_e;
endpackage

// File: rtl/dbic_decode.sv
module dbic_decode
  import dbic_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output rd_sel_e           sel_o,
  output logic [1:0]        en_we_o,
  output logic [1:0]        rt_we_o,
  output logic              ctrl_we_o
);
  always_comb begin
    case (addr_i)
      OFS_IRQ0: sel_o = SEL_IRQ0;
      OFS_EN0:  sel_o = SEL_EN0;
      OFS_RT0:  sel_o = SEL_RT0;
      OFS_FIQ0: sel_o = SEL_FIQ0;
      OFS_PND0: sel_o = SEL_PND0;
      OFS_CTRL: sel_o = SEL_CTRL;
      OFS_HP:   sel_o = SEL_HP;
      OFS_IRQ1: sel_o = SEL_IRQ1;
      OFS_EN1:  sel_o = SEL_EN1;
      OFS_RT1:  sel_o = SEL_RT1;
      OFS_FIQ1: sel_o = SEL_FIQ1;
      OFS_PND1: sel_o = SEL_PND1;
      default:  sel_o = SEL_NONE;
    endcase
  end

  // only the writable registers get a strobe; everything else drops the write
  assign en_we_o[0] = wr_en_i && (sel_o == SEL_EN0);
  assign en_we_o[1] = wr_en_i && (sel_o == SEL_EN1);
  assign rt_we_o[0] = wr_en_i && (sel_o == SEL_RT0);
  assign rt_we_o[1] = wr_en_i && (sel_o == SEL_RT1);
  assign ctrl_we_o  = wr_en_i && (sel_o == SEL_CTRL);

  always_comb begin
    assert_single_strobe_R11: assert ($onehot0({en_we_o, rt_we_o, ctrl_we_o}));
  end
endmodule

// File: rtl/dbic_bank.sv
module dbic_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         en_we_i,
  input  logic         rt_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         wake_all_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] rt_o,
  output logic [W-1:0] irq_view_o,
  output logic [W-1:0] fiq_view_o,
  output logic         irq_any_o,
  output logic         fiq_any_o,
  output logic         wake_any_o
);
  logic [W-1:0] pend_q, en_q, rt_q;
  logic         live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
      rt_q   <= '0;
      live_q <= 1'b0;
    end else begin
      pend_q <= src_i;
      live_q <= 1'b1;
      if (en_we_i) en_q <= wdata_i;
      if (rt_we_i) rt_q <= wdata_i;
    end
  end

  logic [W-1:0] active;
  assign active     = pend_q & en_q;
  assign irq_view_o = active & ~rt_q;
  assign fiq_view_o = active & rt_q;
  assign irq_any_o  = |irq_view_o;
  assign fiq_any_o  = |fiq_view_o;
  assign wake_any_o = |(pend_q & (en_q | {W{wake_all_i}}));

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign rt_o   = rt_q;

  assert_pend_tracks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (pend_q == $past(src_i)));
  assert_en_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (en_q == $past(wdata_i)));
  assert_rt_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_we_i |=> (rt_q == $past(wdata_i)));
  assert_views_disjoint_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_view_o & fiq_view_o) == '0);
endmodule

// File: rtl/dbic_top.sv
module dbic_top
  import dbic_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [BUS_W-1:0]   rdata_o,
  input  logic [BUS_W-1:0]   hp_data_i,
  input  logic               core_halted_i,
  output logic               fiq_o,
  output logic               irq_o,
  output logic               wake_o
);
  localparam int HI_W = NUM_SRC - LO_W;

  rd_sel_e    sel;
  logic [1:0] en_we, rt_we;
  logic       ctrl_we;
  logic       only_en_q;

  dbic_decode u_decode (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .sel_o    (sel),
    .en_we_o  (en_we),
    .rt_we_o  (rt_we),
    .ctrl_we_o(ctrl_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      only_en_q <= 1'b0;
    else if (ctrl_we) only_en_q <= wdata_i[0];
  end

  logic [LO_W-1:0] pnd0, en0, rt0, iv0, fv0;
  logic [HI_W-1:0] pnd1, en1, rt1, iv1, fv1;
  logic [1:0]      irq_any, fiq_any, wake_any;

  dbic_bank #(.W(LO_W)) u_bank_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i[LO_W-1:0]),
    .en_we_i(en_we[0]), .rt_we_i(rt_we[0]), .wdata_i(wdata_i[LO_W-1:0]),
    .wake_all_i(~only_en_q),
    .pend_o(pnd0), .en_o(en0), .rt_o(rt0), .irq_view_o(iv0), .fiq_view_o(fv0),
    .irq_any_o(irq_any[0]), .fiq_any_o(fiq_any[0]), .wake_any_o(wake_any[0])
  );

  dbic_bank #(.W(HI_W)) u_bank_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i[NUM_SRC-1:LO_W]),
    .en_we_i(en_we[1]), .rt_we_i(rt_we[1]), .wdata_i(wdata_i[HI_W-1:0]),
    .wake_all_i(~only_en_q),
    .pend_o(pnd1), .en_o(en1), .rt_o(rt1), .irq_view_o(iv1), .fiq_view_o(fv1),
    .irq_any_o(irq_any[1]), .fiq_any_o(fiq_any[1]), .wake_any_o(wake_any[1])
  );

  assign fiq_o  = |fiq_any;
  assign irq_o  = |irq_any;
  assign wake_o = core_halted_i && (|wake_any);

  logic [BUS_W-1:0] hi_word;
  always_comb begin
    hi_word = '0;
    case (sel)
      SEL_IRQ1: hi_word[HI_W-1:0] = iv1;
      SEL_EN1:  hi_word[HI_W-1:0] = en1;
      SEL_RT1:  hi_word[HI_W-1:0] = rt1;
      SEL_FIQ1: hi_word[HI_W-1:0] = fv1;
      SEL_PND1: hi_word[HI_W-1:0] = pnd1;
      default:  hi_word = '0;
    endcase
  end

  always_comb begin
    case (sel)
      SEL_IRQ0: rdata_o = iv0;
      SEL_EN0:  rdata_o = en0;
      SEL_RT0:  rdata_o = rt0;
      SEL_FIQ0: rdata_o = fv0;
      SEL_PND0: rdata_o = pnd0;
      SEL_CTRL: rdata_o = {{(BUS_W-1){1'b0}}, only_en_q};
      SEL_HP:   rdata_o = hp_data_i;
      SEL_IRQ1, SEL_EN1, SEL_RT1, SEL_FIQ1, SEL_PND1: rdata_o = hi_word;
      default:  rdata_o = '0;
    endcase
  end

  assert_fiq_needs_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> ((|(pnd0 & en0 & rt0)) || (|(pnd1 & en1 & rt1))));
  assert_irq_needs_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((|(pnd0 & en0)) || (|(pnd1 & en1))));
  assert_wake_needs_halt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_halted_i |-> !wake_o);
  assert_ro_write_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(sel inside {SEL_EN0, SEL_EN1, SEL_RT0, SEL_RT1, SEL_CTRL}))
    |=> $stable({en0, en1, rt0, rt1, only_en_q}));
  assert_ctrl_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_CTRL) |=> (only_en_q == $past(wdata_i[0])));
endmodule

// File: tb/dbic_top_bench.sv
`timescale 1ns/1ps
module dbic_top_bench;
  localparam int NS = 36;
  localparam int HW = NS - 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [31:0]   hp = '0;
  logic          halted = 1'b0;
  logic          fiq, irq, wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dbic_top #(.NUM_SRC(NS)) u_dbic_top (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .hp_data_i(hp), .core_halted_i(halted),
    .fiq_o(fiq), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_src(input logic [NS-1:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [HW-1:0] hmask;
    hmask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    foreach (d[i]) ; // no-op to keep d declared usage simple
    begin
      logic [7:0] offs [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                8'h9C, 8'hA0, 8'hA4, 8'hA8, 8'hAC};
      foreach (offs[k]) begin
        rd(offs[k], d);
        chk($sformatf("R10 reset read %h", offs[k]), d, 32'h0);
      end
    end
    halted = 1'b1;
    #1 chk("R10 reset outputs", {29'b0, fiq, irq, wake}, 32'h0);
    halted = 1'b0;

    // R12: lookup pass-through
    hp = 32'h8000_0025;
    rd(8'h18, d); chk("R12 hp read", d, 32'h8000_0025);
    hp = 32'h003F_003F;
    rd(8'h18, d); chk("R12 hp read", d, 32'h003F_003F);

    // R5: readback and unstored upper bits of high bank
    wr(8'h04, 32'hA5A5_0F0F); rd(8'h04, d); chk("R5 en0 readback", d, 32'hA5A5_0F0F);
    wr(8'h08, 32'h1234_5678); rd(8'h08, d); chk("R5 rt0 readback", d, 32'h1234_5678);
    wr(8'hA0, 32'hFFFF_FFFF); rd(8'hA0, d); chk("R5 en1 upper bits", d, {28'b0, hmask});
    wr(8'hA4, 32'hFFFF_FFF5); rd(8'hA4, d); chk("R5 rt1 upper bits", d, 32'h5);

    // R11: writes to read-only and unmapped offsets are dropped
    begin
      logic [7:0] ro [9] = '{8'h00, 8'h0C, 8'h10, 8'h18, 8'h9C, 8'hA8, 8'hAC, 8'h20, 8'hFC};
      foreach (ro[k]) wr(ro[k], 32'hFFFF_FFFF);
    end
    rd(8'h04, d); chk("R11 en0 untouched", d, 32'hA5A5_0F0F);
    rd(8'h08, d); chk("R11 rt0 untouched", d, 32'h1234_5678);
    rd(8'hA0, d); chk("R11 en1 untouched", d, {28'b0, hmask});
    rd(8'hA4, d); chk("R11 rt1 untouched", d, 32'h5);
    rd(8'h14, d); chk("R11 ctrl untouched", d, 32'h0);
    rd(8'h10, d); chk("R11 pend untouched", d, 32'h0);
    #1 chk("R11 outputs quiet", {30'b0, fiq, irq}, 32'h0);
    rd(8'h20, d); chk("R11 unmapped read", d, 32'h0);
    rd(8'h02, d); chk("R11 unaligned read", d, 32'h0);
    rd(8'hB0, d); chk("R11 unmapped read", d, 32'h0);

    // R8: policy register
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); chk("R8 ctrl set", d, 32'h1);
    wr(8'h14, 32'hFFFF_FFFE); rd(8'h14, d); chk("R8 ctrl clear", d, 32'h0);

    // R1: level following, no latching
    set_src(36'h1_0000_0001);
    rd(8'h10, d); chk("R1 pend0 high", d, 32'h1);
    rd(8'hAC, d); chk("R1 pend1 high", d, 32'h1);
    set_src('0);
    rd(8'h10, d); chk("R1 pend0 cleared", d, 32'h0);
    rd(8'hAC, d); chk("R1 pend1 cleared", d, 32'h0);

    // R3 R4 R6 R7: exhaustive high bank with low bank disabled
    wr(8'h04, 32'h0); wr(8'h08, 32'h0);
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        wr(8'hA0, 32'(m)); wr(8'hA4, 32'(s));
        for (int p = 0; p < 16; p++) begin
          logic [3:0] ei, ef;
          ei = 4'(p) & 4'(m) & ~4'(s);
          ef = 4'(p) & 4'(m) & 4'(s);
          @(negedge clk); src = {4'(p), 32'hFFFF_FFFF};
          rd(8'h9C, d); chk("R3 irq view hi", d, {28'b0, ei});
          rd(8'hA8, d); chk("R4 fiq view hi", d, {28'b0, ef});
          rd(8'hAC, d); chk("R2 raw pend hi", d, {28'b0, 4'(p)});
          chk("R6 fiq line hi", {31'b0, fiq}, {31'b0, |ef});
          chk("R7 irq line hi", {31'b0, irq}, {31'b0, |ei});
        end
      end
    end

    // R3 R4 R6 R7: walking source across the low bank, odd sources routed fast
    wr(8'hA0, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h08, 32'hAAAA_AAAA);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      set_src({4'hF, b});
      rd(8'h10, d); chk("R2 raw pend lo", d, b);
      rd(8'h00, d); chk("R3 irq view lo", d, (i % 2) ? 32'h0 : b);
      rd(8'h0C, d); chk("R4 fiq view lo", d, (i % 2) ? b : 32'h0);
      chk("R6 fiq line lo", {31'b0, fiq}, {31'b0, (i % 2) == 1});
      chk("R7 irq line lo", {31'b0, irq}, {31'b0, (i % 2) == 0});
    end

    // mixed low-bank patterns
    begin
      logic [31:0] pat [4][3] = '{'{32'hDEAD_BEEF, 32'h0F0F_F0F0, 32'h3333_CCCC},
                                  '{32'h8000_0001, 32'h8000_0000, 32'h8000_0000},
                                  '{32'h7FFF_FFFE, 32'hFFFF_FFFF, 32'h0000_0000},
                                  '{32'h1357_9BDF, 32'h0000_0000, 32'hFFFF_FFFF}};
      foreach (pat[k]) begin
        wr(8'h04, pat[k][1]); wr(8'h08, pat[k][2]);
        set_src({4'h0, pat[k][0]});
        rd(8'h00, d); chk("R3 irq view mixed", d, pat[k][0] & pat[k][1] & ~pat[k][2]);
        rd(8'h0C, d); chk("R4 fiq view mixed", d, pat[k][0] & pat[k][1] & pat[k][2]);
        chk("R6 fiq mixed", {31'b0, fiq}, {31'b0, |(pat[k][0] & pat[k][1] & pat[k][2])});
        chk("R7 irq mixed", {31'b0, irq}, {31'b0, |(pat[k][0] & pat[k][1] & ~pat[k][2])});
      end
    end

    // R8 R9: wake under both policies, halted and running
    wr(8'h04, 32'h0);
    for (int pol = 0; pol < 2; pol++) begin
      wr(8'h14, 32'(pol));
      for (int m = 0; m < 16; m++) begin
        wr(8'hA0, 32'(m));
        for (int p = 0; p < 16; p++) begin
          logic ew;
          ew = (pol == 0) ? (p != 0) : ((p & m) != 0);
          @(negedge clk); src = {4'(p), 32'h0}; halted = 1'b1;
          @(negedge clk); #1;
          chk("R9 wake halted", {31'b0, wake}, {31'b0, ew});
          halted = 1'b0; #0.5;
          chk("R9 wake running", {31'b0, wake}, 32'h0);
        end
      end
    end
    // low bank wake with policy 1
    wr(8'hA0, 32'h0); wr(8'h04, 32'h0000_0100);
    set_src({4'h0, 32'h0000_0300}); halted = 1'b1; #1;
    chk("R9 wake lo enabled", {31'b0, wake}, 32'h1);
    wr(8'h04, 32'h0000_0400); #1;
    chk("R9 wake lo masked", {31'b0, wake}, 32'h0);
    wr(8'h14, 32'h0); #1;
    chk("R8 wake-all policy", {31'b0, wake}, 32'h1);
    halted = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule